// File: doc/BRIEF.md
# Sync-Triggered Channel Wake Controller

This block holds up to four processing channels in sleep and releases each one at a set number of clock cycles after an external synchronization event. Four asynchronous sync inputs are brought into the clock domain and reduced to rising-edge strobes. Each channel picks one of the four inputs and has its own 16-bit hold-off count. When a qualified edge arrives on its chosen input, the channel loads the count, counts it down on the main clock, and leaves sleep when the count reaches one. When several channels share an input, their individual hold-off values set fixed, known offsets between their start times.

Qualification depends on three control bits: a start-enable, a per-input enable mask, and a first-event-only mode that locks out later edges after one has been taken. Every channel keeps its own copy of these bits. A write to the shared control word loads every copy at once. A write to a channel's own control word changes only that channel. Each time a channel finishes its hold-off, it raises a one-cycle start pulse. This pulse also acts as a frequency-hop command for the downstream oscillator. A write-only sleep command sends a channel back to sleep so that it can be armed again.

Top module: `sws_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycles right after it is released, every `chan_awake` and `start_hop` bit is 0. Asserting `rst_n` clears them at once, without waiting for a clock.
- R2: A channel's 2-bit select code picks its sync input: 0 picks `sync_in[0]`, 1 picks `sync_in[1]`, 2 picks `sync_in[2]` and 3 picks `sync_in[3]`. Edges on the other inputs have no effect on that channel.
- R3: An edge is taken only when the channel's start-enable bit (control bit 4) is 1 and its enable-mask bit for the selected input (control bit n for input n, bits 3:0) is 1. Otherwise the channel stays asleep.
- R4: If the first clock edge that samples the selected input high is edge 1, the channel reads awake after edge H+3, where H is its hold-off value. A hold-off of 0 behaves as 1.
- R5: An input held high counts as one event. A channel put to sleep while its input stays high does not wake again until the input goes low and then high.
- R6: A qualified edge that arrives while a hold-off is counting reloads the count, so the wake time is measured from the later edge.
- R7: With first-event-only mode set (control bit 5), the first qualified edge is taken and all later edges are ignored, even after the channel is put back to sleep. Clearing the bit removes the lockout.
- R8: Register address = {kind[1:0], channel[1:0]}. Kind 0 is the shared control word, which loads all channel control copies. Kind 1 is the hold-off value. Kind 2 is the select code in bits 1:0 plus a sleep command in bit 2. Kind 3 is the channel's own control word, which changes only that channel.
- R9: `start_hop` for a channel is high for exactly one cycle, namely the cycle in which its hold-off completes. A completion while the channel is already awake pulses again and leaves it awake.
- R10: A write of kind 2 with bit 2 set puts the channel to sleep at that clock edge and cancels any hold-off in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| sync_in | input | 4 | Asynchronous sync inputs, index 0 to 3 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address {kind, channel} |
| wr_data | input | 16 | Register write data |
| chan_awake | output | 4 | Per-channel awake flag, 0 = sleep |
| start_hop | output | 4 | One-cycle start-and-hop pulse per channel |

## Verification
Every result of this block falls on a fixed clock edge. A write takes effect at the edge that samples it. A sync input raised between edges produces an accepted edge two clock edges after it is first sampled. The awake flag and the start pulse then appear exactly H+3 edges after that first sampling edge. The bench changes inputs on falling clock edges and samples on falling clock edges. It records the index of the first edge at which each channel reads awake or pulses, and compares that index with H+3, or with no wake at all, inside a window long enough to catch a late wake. Cases that depend on event timing, such as retrigger and lockout, place the second input edge on a known edge so that the expected index is computed directly from R4.

// File: rtl/sws_pkg.sv
package sws_pkg;

  localparam int unsigned SWS_PINS  = 4;
  localparam int unsigned SWS_SEL_W = 2;

  // control word bit positions
  localparam int unsigned CB_START = SWS_PINS;
  localparam int unsigned CB_FIRST = SWS_PINS + 1;
  localparam int unsigned CTRL_W   = SWS_PINS + 2;

  // select-register bit carrying the sleep command
  localparam int unsigned SB_SLEEP = SWS_SEL_W;

  typedef struct packed {
    logic                first_only;
    logic                start_en;
    logic [SWS_PINS-1:0] pin_en;
  } sync_ctrl_t;

  typedef enum logic [1:0] {
    RG_SHARED = 2'd0,
    RG_HOLD   = 2'd1,
    RG_SEL    = 2'd2,
    RG_OWN    = 2'd3
  } reg_kind_e;

endpackage

// File: rtl/sws_sync_edge.sv
module sws_sync_edge #(
  parameter int unsigned PINS   = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] async_in,
  output logic [PINS-1:0] rise
);

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [STAGES-1:0] stage_q, stage_d;
    logic              prev_q, prev_d;

    always_comb begin
      stage_d = {stage_q[STAGES-2:0], async_in[p]};
      prev_d  = stage_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        stage_q <= stage_d;
        prev_q  <= prev_d;
      end
    end

    assign rise[p] = stage_q[STAGES-1] & ~prev_q;

    // R5: an edge strobe never lasts two cycles
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rise[p] |=> !rise[p]);
  end

endmodule

// File: rtl/sws_regs.sv
module sws_regs
  import sws_pkg::*;
#(
  parameter int unsigned N_CHAN = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CH_W  = $clog2(N_CHAN),
  localparam int unsigned ADDR_W = CH_W + 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [N_CHAN-1:0][CNT_W-1:0]       hold_q,
  output logic [N_CHAN-1:0][SWS_SEL_W-1:0]   sel_q,
  output sync_ctrl_t [N_CHAN-1:0]            ctrl_q,
  output logic [N_CHAN-1:0]                  sleep_req
);

  reg_kind_e                              kind;
  logic [CH_W-1:0]                        ch_idx;
  logic [N_CHAN-1:0][CNT_W-1:0]           hold_d;
  logic [N_CHAN-1:0][SWS_SEL_W-1:0]       sel_d;
  sync_ctrl_t [N_CHAN-1:0]                ctrl_d;
  sync_ctrl_t                             wr_ctrl;

  assign kind    = reg_kind_e'(wr_addr[ADDR_W-1 -: 2]);
  assign ch_idx  = wr_addr[CH_W-1:0];
  assign wr_ctrl = sync_ctrl_t'(wr_data[CTRL_W-1:0]);

  always_comb begin
    hold_d    = hold_q;
    sel_d     = sel_q;
    ctrl_d    = ctrl_q;
    sleep_req = '0;
    for (int c = 0; c < N_CHAN; c++) begin
      if (wr_en) begin
        if (kind == RG_SHARED) begin
          ctrl_d[c] = wr_ctrl;
        end else if (ch_idx == CH_W'(c)) begin
          case (kind)
            RG_HOLD: hold_d[c] = wr_data[CNT_W-1:0];
            RG_SEL: begin
              sel_d[c]     = wr_data[SWS_SEL_W-1:0];
              sleep_req[c] = wr_data[SB_SLEEP];
            end
            RG_OWN:  ctrl_d[c] = wr_ctrl;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sel_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      hold_q <= hold_d;
      sel_q  <= sel_d;
      ctrl_q <= ctrl_d;
    end
  end

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chk
    // R8: a shared control write lands in every channel copy
    a_r8_shared_fanout: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[ADDR_W-1 -: 2] == 2'd0)
        |=> ctrl_q[c] == $past(wr_data[CTRL_W-1:0]));
  end

endmodule

// File: rtl/sws_chan.sv
module sws_chan
  import sws_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SWS_PINS-1:0]  rise,
  input  logic [SWS_SEL_W-1:0] sel,
  input  sync_ctrl_t           ctrl,
  input  logic [CNT_W-1:0]     hold,
  input  logic                 sleep_req,
  output logic                 awake,
  output logic                 start_hop
);

  logic             running_q, running_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             awake_q, awake_d;
  logic             pulse_q, pulse_d;
  logic             locked_q, locked_d;
  logic             qualified, accept, cnt_en;
  logic [CNT_W-1:0] load_val;

  assign qualified = rise[sel] && ctrl.start_en && ctrl.pin_en[sel] &&
                     !(ctrl.first_only && locked_q);
  assign accept    = qualified && !sleep_req;
  assign load_val  = (hold == '0) ? CNT_W'(1) : hold;
  assign cnt_en    = accept || running_q;

  always_comb begin
    running_d = running_q;
    cnt_d     = cnt_q;
    awake_d   = awake_q;
    pulse_d   = 1'b0;
    locked_d  = ctrl.first_only ? (locked_q || accept) : 1'b0;
    if (sleep_req) begin
      running_d = 1'b0;
      awake_d   = 1'b0;
    end else if (accept) begin
      running_d = 1'b1;
      cnt_d     = load_val;
    end else if (running_q) begin
      if (cnt_q == CNT_W'(1)) begin
        running_d = 1'b0;
        awake_d   = 1'b1;
        pulse_d   = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      awake_q   <= 1'b0;
      pulse_q   <= 1'b0;
      locked_q  <= 1'b0;
    end else begin
      running_q <= running_d;
      awake_q   <= awake_d;
      pulse_q   <= pulse_d;
      locked_q  <= locked_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign awake     = awake_q;
  assign start_hop = pulse_q;

  // R10: leaving the awake state only follows a sleep command
  a_r10_sleep_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(awake_q) |-> $past(sleep_req));
  // R9: the start pulse coincides with the awake state
  a_r9_pulse_awake: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> awake_q);
  // R9: the start pulse lasts one cycle
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  // R4: a running count never sits at zero
  a_r4_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |-> cnt_q != '0);
  // R6: without a reload the count steps down by one
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && $past(running_q) && !$past(accept))
      |-> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R7: lockout drops once the mode bit is clear
  a_r7_lock_release: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.first_only |=> !locked_q);

endmodule

// File: rtl/sws_wake_ctrl.sv
module sws_wake_ctrl
  import sws_pkg::*;
#(
  parameter int unsigned N_CHAN  = 4,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned STAGES  = 2,
  localparam int unsigned ADDR_W = $clog2(N_CHAN) + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SWS_PINS-1:0] sync_in,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  output logic [N_CHAN-1:0]   chan_awake,
  output logic [N_CHAN-1:0]   start_hop
);

  logic [1:0]                           rst_pipe_q;
  logic                                 rst_sync_n;
  logic [SWS_PINS-1:0]                  rise;
  logic [N_CHAN-1:0][CNT_W-1:0]         hold_q;
  logic [N_CHAN-1:0][SWS_SEL_W-1:0]     sel_q;
  sync_ctrl_t [N_CHAN-1:0]              ctrl_q;
  logic [N_CHAN-1:0]                    sleep_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  sws_sync_edge #(.PINS(SWS_PINS), .STAGES(STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (sync_in),
    .rise     (rise)
  );

  sws_regs #(.N_CHAN(N_CHAN), .CNT_W(CNT_W), .DATA_W(CNT_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .hold_q    (hold_q),
    .sel_q     (sel_q),
    .ctrl_q    (ctrl_q),
    .sleep_req (sleep_req)
  );

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    sws_chan #(.CNT_W(CNT_W)) i_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .rise      (rise),
      .sel       (sel_q[c]),
      .ctrl      (ctrl_q[c]),
      .hold      (hold_q[c]),
      .sleep_req (sleep_req[c]),
      .awake     (chan_awake[c]),
      .start_hop (start_hop[c])
    );
  end

  // R1: nothing is awake or pulsing while the synchronized reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_sync_n |-> (chan_awake == '0 && start_hop == '0));

endmodule

// File: tb/test_sws_wake_ctrl.sv
`timescale 1ns/1ps
module test_sws_wake_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  sync_in;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic [3:0]  chan_awake;
  logic [3:0]  start_hop;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  int wake_at [4];
  int pulse_at[4];
  int npulse  [4];

  always #2 clk = ~clk;

  sws_wake_ctrl i_sws_wake_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_in    (sync_in),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .chan_awake (chan_awake),
    .start_hop  (start_hop)
  );

  // {ch[1:0], sel[1:0], pin[1:0], hold[7:0], start, mask[3:0], expect_wake}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 2'd0, 2'd0, 8'd1,  1'b1, 4'hF, 1'b1},
    {2'd1, 2'd1, 2'd1, 8'd5,  1'b1, 4'h2, 1'b1},
    {2'd2, 2'd2, 2'd2, 8'd12, 1'b1, 4'h4, 1'b1},
    {2'd3, 2'd3, 2'd3, 8'd3,  1'b1, 4'h8, 1'b1},
    {2'd0, 2'd1, 2'd0, 8'd4,  1'b1, 4'hF, 1'b0},
    {2'd1, 2'd2, 2'd2, 8'd4,  1'b0, 4'hF, 1'b0},
    {2'd2, 2'd3, 2'd3, 8'd4,  1'b1, 4'h7, 1'b0},
    {2'd3, 2'd0, 2'd0, 8'd0,  1'b1, 4'h1, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] kind, input int ch, input logic [15:0] d);
    wr_en   = 1'b1;
    wr_addr = {kind, 2'(ch)};
    wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  // raise a pin at the current falling edge; edge 1 is the next rising edge
  task automatic run(input int pin, input int gap, input bit keep, input int ncyc);
    for (int c = 0; c < 4; c++) begin wake_at[c] = 0; pulse_at[c] = 0; npulse[c] = 0; end
    sync_in[pin] = 1'b1;
    for (int k = 1; k <= ncyc; k++) begin
      @(posedge clk); @(negedge clk);
      for (int c = 0; c < 4; c++) begin
        if (chan_awake[c] && wake_at[c] == 0) wake_at[c] = k;
        if (start_hop[c]) begin
          npulse[c]++;
          if (pulse_at[c] == 0) pulse_at[c] = k;
        end
      end
      if (k == 1 && !keep) sync_in[pin] = 1'b0;
      if (gap > 0 && k == gap)     sync_in[pin] = 1'b1;
      if (gap > 0 && k == gap + 1) sync_in[pin] = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; sync_in = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    idle(3);
    check(chan_awake == 4'h0 && start_hop == 4'h0, "R1 in reset", chan_awake, 0);
    rst_n = 1'b1;
    idle(4);
    check(chan_awake == 4'h0 && start_hop == 4'h0, "R1 after release", chan_awake, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      automatic int ch   = int'(VEC[v][19:18]);
      automatic int sel  = int'(VEC[v][17:16]);
      automatic int pin  = int'(VEC[v][15:14]);
      automatic int hold = int'(VEC[v][13:6]);
      automatic bit st   = VEC[v][5];
      automatic logic [3:0] mask = VEC[v][4:1];
      automatic bit exp  = VEC[v][0];
      automatic int eff  = (hold == 0) ? 1 : hold;
      automatic int exp_at = exp ? eff + 3 : 0;
      automatic string tag = exp ? ((hold == 0) ? "R4 zero hold" : "R2 select") : "R3 qualify";
      wr(2'd2, ch, 16'(sel) | 16'h0004);
      check(chan_awake[ch] == 1'b0, "R10 sleep cmd", chan_awake[ch], 0);
      wr(2'd1, ch, 16'(hold));
      wr(2'd3, ch, {10'd0, 1'b0, st, mask});
      run(pin, 0, 0, hold + 10);
      check(wake_at[ch] == exp_at, tag, wake_at[ch], exp_at);
      check(npulse[ch] == int'(exp) && pulse_at[ch] == exp_at, "R9 pulse", pulse_at[ch], exp_at);
    end

    // shared control reaches all, own write overrides one
    wr(2'd0, 0, 16'h0011);
    for (int c = 0; c < 4; c++) begin
      wr(2'd2, c, 16'h0004);
      wr(2'd1, c, 16'(2 + c));
    end
    wr(2'd3, 2, 16'h0001);
    run(0, 0, 0, 15);
    check(wake_at[0] == 5, "R8 shared ch0", wake_at[0], 5);
    check(wake_at[1] == 6, "R8 shared ch1", wake_at[1], 6);
    check(wake_at[2] == 0, "R8 own override ch2", wake_at[2], 0);
    check(wake_at[3] == 8, "R8 shared ch3", wake_at[3], 8);

    // retrigger
    wr(2'd2, 0, 16'h0004);
    wr(2'd1, 0, 16'd10);
    run(0, 4, 0, 25);
    check(wake_at[0] == 17, "R6 retrigger", wake_at[0], 17);
    check(npulse[0] == 1, "R6 single pulse", npulse[0], 1);

    // first-event-only
    wr(2'd2, 0, 16'h0004);
    wr(2'd3, 0, 16'h0031);
    run(0, 4, 0, 25);
    check(wake_at[0] == 13, "R7 first only", wake_at[0], 13);
    wr(2'd2, 0, 16'h0004);
    run(0, 0, 0, 20);
    check(wake_at[0] == 0, "R7 locked", wake_at[0], 0);
    wr(2'd3, 0, 16'h0011);
    run(0, 0, 0, 20);
    check(wake_at[0] == 13, "R7 release", wake_at[0], 13);

    // held level counts once
    wr(2'd2, 1, 16'h0004);
    wr(2'd1, 1, 16'd2);
    wr(2'd3, 1, 16'h0011);
    run(0, 0, 1, 10);
    check(wake_at[1] == 5, "R5 first level", wake_at[1], 5);
    wr(2'd2, 1, 16'h0004);
    run(0, 0, 1, 12);
    check(wake_at[1] == 0, "R5 level held", wake_at[1], 0);
    sync_in[0] = 1'b0;
    idle(4);

    // completion while awake pulses again
    run(0, 0, 0, 10);
    check(wake_at[1] == 5, "R9 wake", wake_at[1], 5);
    run(0, 0, 0, 10);
    check(pulse_at[1] == 5 && npulse[1] == 1, "R9 repeat pulse", pulse_at[1], 5);
    check(chan_awake[1] == 1'b1, "R9 stays awake", chan_awake[1], 1);

    // sleep cancels a running count
    wr(2'd2, 1, 16'h0004);
    wr(2'd1, 1, 16'd20);
    run(0, 0, 0, 5);
    wr(2'd2, 1, 16'h0004);
    begin
      automatic int seen = 0;
      for (int i = 0; i < 30; i++) begin
        @(posedge clk); @(negedge clk);
        if (chan_awake[1] || start_hop[1]) seen++;
      end
      check(seen == 0, "R10 cancel", seen, 0);
    end

    // asynchronous reset while awake
    check(chan_awake[0] == 1'b1, "R1 pre-reset awake", chan_awake[0], 1);
    rst_n = 1'b0;
    #1;
    check(chan_awake == 4'h0 && start_hop == 4'h0, "R1 async clear", chan_awake, 0);
    idle(2);
    rst_n = 1'b1;
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule